// File: doc/BRIEF.md
# APB Transfer Protocol Monitor

This block watches an APB3 bus without driving any of its signals. From the select, enable and ready lines it follows every transfer through its idle, setup and access phases. It reports each way in which either the requester or the completer breaks the transfer sequence. Every kind of violation has its own flag, which stays set until reset. A one-cycle pulse marks each cycle in which a rule was broken. Three saturating counters record completed transfers, error responses and wait cycles.

The monitor is placed beside a bus segment in a larger design so that protocol faults are caught where they occur. Read data plays no part in any rule that the monitor checks, so it is not an input.

All outputs are registered. A condition that appears on the inputs in one clock cycle shows up on the outputs just after the following rising edge.

Top module: `apb_txn_monitor`

## Requirements
- R1: While `rstN` is low, every flag, the pulse and all three counters read zero.
- R2: `xferCount` increments once for each completing cycle. A completing cycle has `psel`, `penable` and `pready` all high, and comes directly after a setup cycle or after a waiting access cycle.
- R3: `errCount` increments only when `pslverr` is high in a completing cycle. `pslverr` in any other cycle has no effect.
- R4: `waitCount` increments for every valid access cycle that has `pready` low.
- R5: Flag bit 0 (sequence) is set when the cycle after a setup cycle, or after a waiting access cycle, is not an access cycle (`psel` and `penable` both high).
- R6: Flag bit 1 is set when `penable` is high while `psel` is low.
- R7: Flag bit 2 is set when an access cycle starts from idle, with no setup cycle before it.
- R8: Flag bit 3 is set when `penable` is still high in the cycle that follows a completing cycle.
- R9: Flag bit 4 is set when any of the following differs during a valid access cycle from its value in the setup cycle: `paddr`; `pwrite`; or `pwdata` on a write transfer. A change in `pwdata` during a read does not set it.
- R10: Flags stay set until reset. `violPulse` is high for exactly one cycle after each cycle that breaks at least one rule.
- R11: Each counter is `CNT_W` bits wide (16 by default) and holds at its maximum value instead of wrapping.
- R12: A completing cycle followed by a setup cycle, with `psel` held high, starts a new transfer without raising any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access phase enable |
| pwrite | input | 1 | Transfer direction, high for write |
| paddr | input | ADDR_W | Transfer address |
| pwdata | input | DATA_W | Write data |
| pready | input | 1 | Completer ready, stretches access when low |
| pslverr | input | 1 | Completer error response |
| violSticky | output | 5 | Sticky violation flags, bit order as in R5 to R9 |
| violPulse | output | 1 | One-cycle pulse per violating cycle |
| xferCount | output | CNT_W | Completed transfers |
| errCount | output | CNT_W | Error responses |
| waitCount | output | CNT_W | Wait cycles |

## Verification
The assertions assume that bus inputs are stable around the rising clock edge and that reset is applied from time zero. They also assume that each violation rule is judged only against the phase reached at the previous edge. None of them depends on the bus being well behaved, so the stimulus can break rules on purpose. The stimulus changes inputs only on falling edges. It breaks one rule at a time, with legal transfers in between, so the effect of each broken rule on its own flag and on the pulse can be seen separately.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

  // Phase reached by the previous bus cycle
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  // Violation bit positions (visible on the sticky flag port)
  localparam int V_SEQ      = 0;
  localparam int V_NOSEL    = 1;
  localparam int V_NOSETUP  = 2;
  localparam int V_STUCK    = 3;
  localparam int V_UNSTABLE = 4;
  localparam int NUM_VIOL   = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic checkStable;
    logic countXfer;
    logic countErr;
    logic countWait;
  } strobe_t;

endpackage

// File: rtl/apb_mon_satcnt.sv
module apb_mon_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     value <= '0;
    else if (inc && value != MAXV) value <= value + 1'b1;
  end
endmodule

// File: rtl/apb_mon_ctrl.sv
module apb_mon_ctrl
  import apb_mon_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pready,
  input  logic                pslverr,
  output strobe_t             strobes,
  output logic [NUM_VIOL-2:0] seqViol
);
  phase_e phase, phaseNext;
  logic   accessNow, expectAccess, validAccess;

  assign accessNow    = psel && penable;
  assign expectAccess = (phase == PH_SETUP) || (phase == PH_WAIT);
  assign validAccess  = accessNow && expectAccess;

  always_comb begin
    if (validAccess)          phaseNext = pready ? PH_DONE : PH_WAIT;
    else if (psel && !penable) phaseNext = PH_SETUP;
    else                      phaseNext = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    seqViol            = '0;
    seqViol[V_SEQ]     = expectAccess && !accessNow;
    seqViol[V_NOSEL]   = penable && !psel;
    seqViol[V_NOSETUP] = accessNow && (phase == PH_IDLE);
    seqViol[V_STUCK]   = penable && (phase == PH_DONE);
  end

  always_comb begin
    strobes.capture     = psel && !penable;
    strobes.checkStable = validAccess;
    strobes.countXfer   = validAccess && pready;
    strobes.countErr    = validAccess && pready && pslverr;
    strobes.countWait   = validAccess && !pready;
  end
endmodule

// File: rtl/apb_mon_datapath.sv
module apb_mon_datapath
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [NUM_VIOL-2:0] seqViol,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [NUM_VIOL-1:0] violSticky,
  output logic                violPulse,
  output logic [CNT_W-1:0]    xferCount,
  output logic [CNT_W-1:0]    errCount,
  output logic [CNT_W-1:0]    waitCount
);
  localparam int NUM_CNT = 3;

  logic [ADDR_W-1:0]   capAddr;
  logic [DATA_W-1:0]   capData;
  logic                capWrite;
  logic                unstable;
  logic [NUM_VIOL-1:0] violNow;
  logic [NUM_CNT-1:0]  incVec;
  logic [CNT_W-1:0]    cntVal [NUM_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr  <= '0;
      capData  <= '0;
      capWrite <= 1'b0;
    end else if (strobes.capture) begin
      capAddr  <= paddr;
      capData  <= pwdata;
      capWrite <= pwrite;
    end
  end

  assign unstable = strobes.checkStable &&
                    ((paddr != capAddr) || (pwrite != capWrite) ||
                     (capWrite && (pwdata != capData)));

  assign violNow = {unstable, seqViol};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violSticky <= '0;
      violPulse  <= 1'b0;
    end else begin
      violSticky <= violSticky | violNow;
      violPulse  <= |violNow;
    end
  end

  assign incVec = {strobes.countWait, strobes.countErr, strobes.countXfer};

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    apb_mon_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (incVec[gi]),
      .value (cntVal[gi])
    );
  end

  assign xferCount = cntVal[0];
  assign errCount  = cntVal[1];
  assign waitCount = cntVal[2];
endmodule

// File: rtl/apb_txn_monitor.sv
module apb_txn_monitor
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic                pready,
  input  logic                pslverr,
  output logic [NUM_VIOL-1:0] violSticky,
  output logic                violPulse,
  output logic [CNT_W-1:0]    xferCount,
  output logic [CNT_W-1:0]    errCount,
  output logic [CNT_W-1:0]    waitCount
);
  strobe_t             strobes;
  logic [NUM_VIOL-2:0] seqViol;

  apb_mon_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pready  (pready),
    .pslverr (pslverr),
    .strobes (strobes),
    .seqViol (seqViol)
  );

  apb_mon_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .seqViol    (seqViol),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .violSticky (violSticky),
    .violPulse  (violPulse),
    .xferCount  (xferCount),
    .errCount   (errCount),
    .waitCount  (waitCount)
  );
endmodule

// File: rtl/apb_mon_checker.sv
module apb_mon_checker
  import apb_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                psel,
  input logic                penable,
  input logic                pready,
  input logic [NUM_VIOL-1:0] violSticky,
  input logic                violPulse,
  input logic [CNT_W-1:0]    xferCount,
  input logic [CNT_W-1:0]    errCount,
  input logic [CNT_W-1:0]    waitCount
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R10: flags never clear outside reset
  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((violSticky & $past(violSticky)) == $past(violSticky)));

  // R10: a pulse always comes with at least one flag
  p_pulse_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> (violSticky != '0));

  // R6: enable without select is flagged and pulsed
  p_enable_nosel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (penable && !psel) |=> (violSticky[V_NOSEL] && violPulse));

  // R2: transfer count moves only on a ready access cycle
  p_xfer_needs_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(psel && penable && pready) |=> $stable(xferCount));

  // R3: errors never outnumber completions
  p_err_le_xfer_r3: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= xferCount);

  // R4: wait count steps by at most one and only with ready low
  p_wait_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((waitCount == $past(waitCount)) ||
              ((waitCount == $past(waitCount) + 1'b1) && !$past(pready))));

  // R11: a full counter stays full
  p_wait_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    (waitCount == CMAX) |=> (waitCount == CMAX));
endmodule

bind apb_txn_monitor apb_mon_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .psel       (psel),
  .penable    (penable),
  .pready     (pready),
  .violSticky (violSticky),
  .violPulse  (violPulse),
  .xferCount  (xferCount),
  .errCount   (errCount),
  .waitCount  (waitCount)
);

// File: tb/test_apb_txn_monitor.sv
module test_apb_txn_monitor;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int CMAXI = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic          pready = 1'b0, pslverr = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [4:0]    violSticky;
  logic          violPulse;
  logic [CW-1:0] xferCount, errCount, waitCount;

  always #10 clk = ~clk;

  apb_txn_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_apb_txn_monitor (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
    .violSticky(violSticky), .violPulse(violPulse),
    .xferCount(xferCount), .errCount(errCount), .waitCount(waitCount)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Behavioural model: 0 idle, 1 after setup, 2 after wait, 3 after done
  int mPh = 0;
  int mX = 0, mE = 0, mW = 0;
  bit mFlag [5];
  bit mPulse = 0;
  logic [AW-1:0] mA = '0;
  logic [DW-1:0] mD = '0;
  logic          mWr = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mPh = 0; mX = 0; mE = 0; mW = 0; mPulse = 0;
    mA = '0; mD = '0; mWr = 1'b0;
    foreach (mFlag[i]) mFlag[i] = 0;
  endtask

  task automatic compareAll();
    string tags [5] = '{"R5", "R6", "R7", "R8", "R9"};
    for (int i = 0; i < 5; i++) chk(tags[i], int'(violSticky[i]), int'(mFlag[i]));
    chk("R10", int'(violPulse), int'(mPulse));
    chk("R2", int'(xferCount), mX);
    chk("R3", int'(errCount), mE);
    chk("R4", int'(waitCount), mW);
  endtask

  task automatic modelUpdate(input bit s, e, r, er, input logic [AW-1:0] a,
                             input logic w, input logic [DW-1:0] d);
    bit acc, expAcc, valid;
    bit v [5];
    acc    = s && e;
    expAcc = (mPh == 1) || (mPh == 2);
    valid  = acc && expAcc;
    v[0] = expAcc && !acc;
    v[1] = e && !s;
    v[2] = acc && (mPh == 0);
    v[3] = e && (mPh == 3);
    v[4] = valid && ((a != mA) || (w != mWr) || (mWr && (d != mD)));
    mPulse = 0;
    for (int i = 0; i < 5; i++) begin
      if (v[i]) begin mFlag[i] = 1; mPulse = 1; end
    end
    if (valid && r && mX < CMAXI) mX++;
    if (valid && r && er && mE < CMAXI) mE++;
    if (valid && !r && mW < CMAXI) mW++;
    if (s && !e) begin mA = a; mD = d; mWr = w; end
    if (valid) mPh = r ? 3 : 2;
    else if (s && !e) mPh = 1;
    else mPh = 0;
  endtask

  task automatic step(input bit s, e, r, er, input logic [AW-1:0] a,
                      input logic w, input logic [DW-1:0] d);
    @(negedge clk);
    compareAll();
    psel = s; penable = e; pready = r; pslverr = er;
    paddr = a; pwrite = w; pwdata = d;
    modelUpdate(s, e, r, er, a, w, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0, '0);
  endtask

  task automatic doReset();
    @(negedge clk);
    compareAll();
    rstN = 1'b0;
    psel = 0; penable = 0; pready = 0; pslverr = 0; paddr = '0; pwrite = 0; pwdata = '0;
    modelReset();
    @(negedge clk);
    // R1: everything reads zero during reset
    chk("R1", int'(violSticky), 0);
    chk("R1", int'(violPulse), 0);
    chk("R1", int'(xferCount), 0);
    chk("R1", int'(errCount), 0);
    chk("R1", int'(waitCount), 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    idle(2);
    // R2: write with no wait
    step(1, 0, 0, 0, 32'h10, 1, 32'hA5A5_0001);
    step(1, 1, 1, 0, 32'h10, 1, 32'hA5A5_0001);
    idle(1);
    // R4, R9: read with two waits, write data moving (not flagged)
    step(1, 0, 0, 0, 32'h20, 0, 32'h1);
    step(1, 1, 0, 0, 32'h20, 0, 32'h2);
    step(1, 1, 0, 0, 32'h20, 0, 32'h3);
    step(1, 1, 1, 0, 32'h20, 0, 32'h4);
    idle(1);
    // R3: error seen in idle, setup and wait is ignored; counted at completion
    step(0, 0, 0, 1, 32'h0, 0, 32'h0);
    step(1, 0, 0, 1, 32'h30, 1, 32'h77);
    step(1, 1, 0, 1, 32'h30, 1, 32'h77);
    step(1, 1, 1, 1, 32'h30, 1, 32'h77);
    idle(2);
    // R12: back-to-back transfers with select held high
    step(1, 0, 0, 0, 32'h40, 1, 32'h11);
    step(1, 1, 1, 0, 32'h40, 1, 32'h11);
    step(1, 0, 0, 0, 32'h44, 0, 32'h22);
    step(1, 1, 1, 0, 32'h44, 0, 32'h22);
    idle(1);
    @(negedge clk);
    chk("R12", int'(violSticky), 0);
    chk("R12", int'(xferCount), 5);
    // R8: enable held high after completion
    step(1, 0, 0, 0, 32'h50, 1, 32'h5);
    step(1, 1, 1, 0, 32'h50, 1, 32'h5);
    step(1, 1, 1, 0, 32'h50, 1, 32'h5);
    idle(2);
    // R9: address moves during access
    step(1, 0, 0, 0, 32'h60, 1, 32'h6);
    step(1, 1, 1, 0, 32'h64, 1, 32'h6);
    idle(2);
    // R5: setup not followed by access
    step(1, 0, 0, 0, 32'h70, 0, 32'h0);
    idle(2);
    // R6: enable without select
    step(0, 1, 0, 0, 32'h0, 0, 32'h0);
    idle(2);
    // R7: access straight from idle
    step(1, 1, 1, 0, 32'h80, 0, 32'h0);
    idle(2);
    @(negedge clk);
    chk("R10", int'(violSticky), 31);
    // R10: reset clears sticky flags
    doReset();
    idle(2);
    // R11: wait counter saturation
    step(1, 0, 0, 0, 32'h90, 0, 32'h0);
    for (int i = 0; i < CMAXI + 5; i++) step(1, 1, 0, 0, 32'h90, 0, 32'h0);
    step(1, 1, 1, 0, 32'h90, 0, 32'h0);
    idle(2);
    @(negedge clk);
    chk("R11", int'(waitCount), CMAXI);
    chk("R11", int'(xferCount), 1);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule